// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This block takes a 16-bit IEEE-754 binary16 value and produces the 32-bit binary32 value that is exactly equal to it. No rounding is needed, because every binary16 value fits exactly in binary32. The block sorts each input into one of five classes: zero, subnormal, normal, infinity or NaN. It moves the exponent from bias 15 to bias 127. A subnormal input is renormalised by counting the leading zeros of its fraction.

NaN inputs are handled the way a processor would handle them. When the `dflt_nan` control is set, every NaN becomes the single canonical quiet NaN. When it is clear, the sign and payload are kept and the result is forced quiet. A signalling NaN sets a sticky invalid-operation flag, which stays set until `flag_clr` is pulsed.

Each conversion is qualified by `in_valid`. The result is registered and appears one clock later together with `out_valid`.

Top module: `h2s_widen`

## Requirements
- R1: An input with exponent field 0 and fraction 0 gives a binary32 zero with the same sign bit (0x00000000 or 0x80000000).
- R2: An input with exponent field 31 and fraction 0 gives 0x7F800000 when its sign is 0 and 0xFF800000 when its sign is 1.
- R3: An input with an exponent field from 1 to 30 gives the same sign, an exponent field equal to the input exponent plus 112, and a fraction equal to the input fraction followed by 13 zero bits.
- R4: An input with exponent field 0 and a nonzero fraction f (value f·2^-24) gives a normal binary32 of the same value. With k the number of leading zeros of f in 10 bits, the exponent field is 112−k and the fraction is f shifted left by k+1 (top bit dropped, 10 bits kept) followed by 13 zeros.
- R5: With `dflt_nan`=1, any NaN input (exponent 31, fraction nonzero) gives exactly 0x7FC00000.
- R6: With `dflt_nan`=0, a NaN input gives sign unchanged, exponent 0xFF, fraction bit 22 set to 1, fraction bits 21..13 equal to input fraction bits 8..0, and fraction bits 12..0 zero.
- R7: An accepted NaN whose fraction bit 9 is 0 (a signalling NaN) sets `inv_flag` one cycle later, whatever the value of `dflt_nan`. A quiet NaN or a non-NaN input does not set it.
- R8: `inv_flag` is sticky. It clears only on a cycle with `flag_clr`=1 and no accepted signalling NaN. If both happen in the same cycle, the flag ends set.
- R9: `out_valid` equals `in_valid` delayed by one cycle. The result appears on `out_word` one cycle after acceptance. While `in_valid`=0, `out_word` holds its previous value.
- R10: While `rst_n` is low, `out_valid`, `out_word` and `inv_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_half` and `dflt_nan` for one conversion |
| in_half | input | 16 | binary16 operand |
| dflt_nan | input | 1 | 1: every NaN becomes the canonical quiet NaN |
| flag_clr | input | 1 | Clears the sticky invalid-operation flag |
| out_valid | output | 1 | Result on `out_word` is new this cycle |
| out_word | output | 32 | binary32 result |
| inv_flag | output | 1 | Sticky invalid-operation flag (signalling NaN seen) |

## Verification
Every result is due exactly one clock after the edge that accepts it. This holds for `out_word`, for `out_valid`, and for the update of `inv_flag`, because each passes through a single register stage.

The bench drives its inputs at the falling edge. It advances its model at the next rising edge and compares at the falling edge that follows, so each comparison falls in the cycle where the registered output has just changed.

Every binary16 code is swept under both settings of `dflt_nan`. Directed steps cover the flag's set, hold, clear and clear-versus-set behaviour, and the holding of `out_word` while idle.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_FRC_W = 10;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRC_W  = 23;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_NAN  = 3'd4
  } fp_class_e;

  // Exponent offset between two biased formats
  function automatic int rebias(input int src_ew, input int dst_ew);
    return ((2 ** (dst_ew - 1)) - 1) - ((2 ** (src_ew - 1)) - 1);
  endfunction
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
#(
  parameter int EW = HALF_EXP_W,
  parameter int FW = HALF_FRC_W
) (
  input  logic [EW-1:0] exp_fld,
  input  logic [FW-1:0] frc_fld,
  output fp_class_e     cls,
  output logic          snan
);
  logic exp_zero, exp_full, frc_zero;

  assign exp_zero = (exp_fld == '0);
  assign exp_full = (exp_fld == '1);
  assign frc_zero = (frc_fld == '0);

  always_comb begin
    if (exp_zero)      cls = frc_zero ? CL_ZERO : CL_SUB;
    else if (exp_full) cls = frc_zero ? CL_INF  : CL_NAN;
    else               cls = CL_NORM;
  end

  assign snan = exp_full && !frc_zero && !frc_fld[FW-1];
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic found;

  always_comb begin
    cnt   = CW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
  import h2s_pkg::*;
#(
  parameter int HE = HALF_EXP_W,
  parameter int HF = HALF_FRC_W,
  parameter int SE = SGL_EXP_W,
  parameter int SF = SGL_FRC_W,
  localparam int CW = $clog2(HF + 1)
) (
  input  logic          sgn,
  input  logic [HE-1:0] exp_fld,
  input  logic [HF-1:0] frc_fld,
  input  fp_class_e     cls,
  input  logic [CW-1:0] lz,
  input  logic          dflt_nan,
  output logic [SE+SF:0] word
);
  localparam int PAD = SF - HF;
  localparam int RB  = rebias(HE, SE);

  logic [HF-1:0] sub_frc;
  logic [SE-1:0] sub_exp, nrm_exp;

  assign sub_frc = frc_fld << (lz + 1'b1);
  assign sub_exp = SE'(RB) - SE'(lz);
  assign nrm_exp = SE'(RB) + SE'(exp_fld);

  always_comb begin
    unique case (cls)
      CL_ZERO: word = {sgn, {(SE + SF){1'b0}}};
      CL_INF:  word = {sgn, {SE{1'b1}}, {SF{1'b0}}};
      CL_SUB:  word = {sgn, sub_exp, sub_frc, {PAD{1'b0}}};
      CL_NAN: begin
        if (dflt_nan) word = {1'b0, {SE{1'b1}}, 1'b1, {(SF - 1){1'b0}}};
        else          word = {sgn, {SE{1'b1}}, 1'b1, frc_fld[HF-2:0], {PAD{1'b0}}};
      end
      default: word = {sgn, nrm_exp, frc_fld, {PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
#(
  parameter int HE = HALF_EXP_W,
  parameter int HF = HALF_FRC_W,
  parameter int SE = SGL_EXP_W,
  parameter int SF = SGL_FRC_W,
  localparam int HW = 1 + HE + HF,
  localparam int SW = 1 + SE + SF,
  localparam int CW = $clog2(HF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [HW-1:0] in_half,
  input  logic          dflt_nan,
  input  logic          flag_clr,
  output logic          out_valid,
  output logic [SW-1:0] out_word,
  output logic          inv_flag
);
  fp_class_e     cls;
  logic          snan_evt, nan_evt;
  logic [CW-1:0] lz;
  logic [SW-1:0] conv;

  h2s_classify #(.EW(HE), .FW(HF)) u_cls (
    .exp_fld (in_half[HW-2 -: HE]),
    .frc_fld (in_half[HF-1:0]),
    .cls     (cls),
    .snan    (snan_evt)
  );

  h2s_lzc #(.W(HF)) u_lzc (
    .vec (in_half[HF-1:0]),
    .cnt (lz)
  );

  h2s_assemble #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) u_asm (
    .sgn      (in_half[HW-1]),
    .exp_fld  (in_half[HW-2 -: HE]),
    .frc_fld  (in_half[HF-1:0]),
    .cls      (cls),
    .lz       (lz),
    .dflt_nan (dflt_nan),
    .word     (conv)
  );

  assign nan_evt = (cls == CL_NAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      inv_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= conv;
      inv_flag <= (inv_flag && !flag_clr) || (in_valid && snan_evt);
    end
  end
endmodule

// File: rtl/h2s_widen_chk.sv
module h2s_widen_chk #(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23,
  localparam int HW = 1 + HE + HF,
  localparam int SW = 1 + SE + SF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [HW-1:0] in_half,
  input logic          dflt_nan,
  input logic          flag_clr,
  input logic          out_valid,
  input logic [SW-1:0] out_word,
  input logic          inv_flag,
  input logic          nan_evt,
  input logic          snan_evt
);
  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[HW-2:0] == '0) |=> (out_word[SW-2:0] == '0));

  p_inf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[HW-2:0] == {{HE{1'b1}}, {HF{1'b0}}})
      |=> (out_word[SW-2:0] == {{SE{1'b1}}, {SF{1'b0}}}));

  p_dnan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dflt_nan && nan_evt)
      |=> (out_word == {1'b0, {SE{1'b1}}, 1'b1, {(SF - 1){1'b0}}}));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_evt) |=> (out_word[SW-2 -: SE + 1] == '1));

  p_snan_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && snan_evt) |=> inv_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_flag && !flag_clr) |=> inv_flag);

  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_flag && !(in_valid && snan_evt)) |=> !inv_flag);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word)));
endmodule

bind h2s_widen h2s_widen_chk #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_half   (in_half),
  .dflt_nan  (dflt_nan),
  .flag_clr  (flag_clr),
  .out_valid (out_valid),
  .out_word  (out_word),
  .inv_flag  (inv_flag),
  .nan_evt   (nan_evt),
  .snan_evt  (snan_evt)
);

// File: tb/test_h2s_widen.sv
`timescale 1ns/1ps
module test_h2s_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        dflt_nan = 1'b0;
  logic        flag_clr = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        inv_flag;

  int checks = 0;
  int errors = 0;

  logic        m_valid = 1'b0;
  logic [31:0] m_word  = '0;
  logic        m_flag  = 1'b0;
  string       m_tag   = "R10";

  always #2 clk = ~clk;

  h2s_widen i_h2s_widen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .dflt_nan(dflt_nan), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_word(out_word), .inv_flag(inv_flag)
  );

  function automatic logic [31:0] ref_conv(input logic [15:0] h, input logic dn);
    int e, f, m, x;
    logic s;
    s = h[15];
    e = int'(h[14:10]);
    f = int'(h[9:0]);
    if (e == 0 && f == 0) return {s, 31'd0};
    if (e == 31 && f == 0) return {s, 8'hFF, 23'd0};
    if (e == 31) begin
      if (dn) return 32'h7FC00000;
      return {s, 8'hFF, 1'b1, h[8:0], 13'd0};
    end
    if (e == 0) begin
      m = f;
      x = -14;
      while (m < 1024) begin
        m = m * 2;
        x = x - 1;
      end
      return {s, 8'(x + 127), 10'(m - 1024), 13'd0};
    end
    return {s, 8'(e - 15 + 127), h[9:0], 13'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] h, input logic dn);
    if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R1" : "R4";
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R2" : (dn ? "R5" : "R6");
    return "R3";
  endfunction

  task automatic compare();
    checks += 3;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL R9 out_valid actual %0b expected %0b", out_valid, m_valid);
    end
    if (out_word !== m_word) begin
      errors++;
      $display("FAIL %s out_word actual %08h expected %08h", m_tag, out_word, m_word);
    end
    if (inv_flag !== m_flag) begin
      errors++;
      $display("FAIL R7/R8 inv_flag actual %0b expected %0b", inv_flag, m_flag);
    end
  endtask

  // Called at a falling edge: drive, advance model at rising edge, check at next fall
  task automatic step(input logic v, input logic [15:0] h, input logic dn, input logic clr);
    logic snan;
    in_valid = v;
    in_half  = h;
    dflt_nan = dn;
    flag_clr = clr;
    snan = (h[14:10] == 5'd31) && (h[9:0] != 0) && !h[9];
    @(posedge clk);
    m_valid = v;
    if (v) begin
      m_word = ref_conv(h, dn);
      m_tag  = tag_of(h, dn);
    end else begin
      m_tag = "R9";
    end
    m_flag = (m_flag && !clr) || (v && snan);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    m_tag = "R10";
    compare();                          // R10 reset state
    rst_n = 1'b1;
    @(negedge clk);
    step(1'b1, 16'h3C00, 1'b0, 1'b0);   // R3 one
    step(1'b0, 16'h0000, 1'b0, 1'b0);   // R9 idle: word holds
    step(1'b1, 16'h7E01, 1'b0, 1'b0);   // R6 quiet NaN, R7 no flag
    step(1'b1, 16'hFC01, 1'b1, 1'b0);   // R5 sNaN default, R7 flag sets
    step(1'b0, 16'h0000, 1'b0, 1'b0);   // R8 flag holds
    step(1'b0, 16'h0000, 1'b0, 1'b1);   // R8 clear
    step(1'b1, 16'h7C2A, 1'b0, 1'b1);   // R8 clear and set together: set wins
    step(1'b1, 16'h7C00, 1'b0, 1'b1);   // R2 infinity, R8 clear
    step(1'b1, 16'h8001, 1'b0, 1'b0);   // R4 smallest subnormal
    step(1'b1, 16'h8000, 1'b0, 1'b0);   // R1 negative zero
    for (int dn = 0; dn < 2; dn++) begin
      for (int c = 0; c < 65536; c++) begin
        step(1'b1, 16'(c), 1'(dn), 1'b0);
      end
    end
    step(1'b0, 16'h1234, 1'b0, 1'b0);   // R9 idle after sweep
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule